// File: doc/BRIEF.md
# Memory March Test Sequencer

A self-test sequencer that drives a small synchronous SRAM (128 words of 32 bits by default) through one of three test programs and reports the first miscompare. Software or a test controller picks a program with `mode`, sets the program's operands and pulses `start`. The sequencer then issues one memory operation per cycle, compares every read word one cycle after the read, and pulses `done` when the program ends.

The march program first fills the array with ones. It then visits each address with a write-0 / read-0 / write-1 element, so the cell under test always reads zero while every other cell on its column holds one. Three further elements follow: a descending read-1/write-0, an ascending read-0/write-1 and a descending read-1. The low-supply program writes every word while it requests the low supply. It then switches the supply back once and reads every word. It waits for the regulator's acknowledge and a programmable settling time around each switch. The stress program writes one word and reads that word back to back a programmable number of times.

The regulator, word-line boosting and the bit-cells are outside the block.

Top module: `mbist_seq`

## Requirements
- R1: The march program (mode 0) first writes all-ones to addresses 0 up to the top address. It then visits addresses 0 up to the top address, and at each one issues write all-zeros, read expecting all-zeros and write all-ones in three consecutive cycles.
- R2: After R1, the march program issues three more elements. The first is descending, read expecting ones then write zeros. The second is ascending, read expecting zeros then write ones. The third is descending, read expecting ones only. The whole program is 9 × 2^AW operations, one per cycle.
- R3: Read data arrives one cycle after `mem_re`. The first word that differs from its expected value sets `fail` and captures its address in `fail_addr`, the expected word in `fail_exp` and the mode in `fail_mode`. Later miscompares change none of these. `fail` stays high until the next accepted `start`.
- R4: With `stop_on_fail` = 0 a miscompare does not shorten the program. With `stop_on_fail` = 1 the cycle after the miscompare is detected is the `done` cycle, so exactly one more operation follows the failing read.
- R5: In mode 1, `sup_low_req` rises on start. All words are written, ascending, while it is high. It then falls, and all words are read, ascending, only while it is low. No read ever occurs while `sup_low_req` is high.
- R6: After each supply request change, the first memory operation comes exactly max(`settle_cycles`,1)+1 cycles after the first cycle in which `sup_ack` equals `sup_low_req`. No operation occurs in between.
- R7: The mode-1 write word, and so its expected read word, is `pattern` on the first mode-1 run after reset and its bitwise complement on the next. It alternates on every completed mode-1 run.
- R8: Mode 2 writes `pattern` once to `tgt_addr`. It then issues max(`repeat_cnt`,1) consecutive reads of `tgt_addr`, each compared against `pattern`.
- R9: After reset, `busy`, `done`, `fail`, `mem_we`, `mem_re` and `sup_low_req` are low. `done` is high for exactly one cycle per run. A `start` while `busy` is high is ignored.
- R10: Mode 3 runs the same program as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the selected program when idle |
| mode | input | 2 | 0/3 march, 1 low-supply write then read, 2 read stress |
| stop_on_fail | input | 1 | End the run at the first miscompare |
| pattern | input | DW | Data word for modes 1 and 2 |
| tgt_addr | input | AW | Target word for mode 2 |
| settle_cycles | input | SW | Wait after each supply acknowledge |
| repeat_cnt | input | RW | Number of stress reads |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Write word (expected word during reads) |
| mem_rdata | input | DW | Read word, one cycle after `mem_re` |
| sup_low_req | output | 1 | Request for the low supply |
| sup_ack | input | 1 | Regulator level, equals the request once settled |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | A miscompare occurred in this run |
| fail_addr | output | AW | Address of the first miscompare |
| fail_exp | output | DW | Expected word of the first miscompare |
| fail_mode | output | 2 | Mode of the run that failed |

## Verification
The bench keeps the default widths: AW = 7, DW = 32, SW = 16 and RW = 4. Every run therefore covers a full 128-word array, and the complete 1152-operation march order can be compared against a computed trace, including the address wrap at both ends. The 16-bit settle counter is driven with zero and with small random values, which exposes the exact gap between acknowledge and first operation without long waits. The 4-bit repeat count reaches both the zero case and its maximum of 15.

// File: rtl/mbist_seq.sv
module mbist_seq #(
  parameter int AW = 7,
  parameter int DW = 32,
  parameter int SW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          stop_on_fail,
  input  logic [DW-1:0] pattern,
  input  logic [AW-1:0] tgt_addr,
  input  logic [SW-1:0] settle_cycles,
  input  logic [RW-1:0] repeat_cnt,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          sup_low_req,
  input  logic          sup_ack,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [1:0]    fail_mode
);
  typedef enum logic [2:0] {S_IDLE, S_SUP, S_WAIT, S_RUN, S_FLUSH, S_DONE} st_t;
  localparam logic [AW-1:0] ATOP = {AW{1'b1}};
  localparam logic [2:0] EL_LAST = 3'd4;

  st_t st;
  logic [1:0] md, op, nops;
  logic [2:0] el;
  logic [AW-1:0] addr, paddr;
  logic [SW-1:0] cnt;
  logic [RW-1:0] rc;
  logic inv, pv, rd_m, dbit, down;
  logic [DW-1:0] pexp;

  always_comb begin
    rd_m = 1'b0; dbit = 1'b1; down = 1'b0; nops = 2'd1;
    case (el)
      3'd0: ;
      3'd1: begin nops = 2'd3; rd_m = (op == 2'd1); dbit = (op == 2'd2); end
      3'd2: begin nops = 2'd2; down = 1'b1; rd_m = (op == 2'd0); dbit = (op == 2'd0); end
      3'd3: begin nops = 2'd2; rd_m = (op == 2'd0); dbit = (op == 2'd1); end
      default: begin down = 1'b1; rd_m = 1'b1; end
    endcase
  end

  wire march = (md == 2'd0) || (md == 2'd3);
  wire is_rd = march ? rd_m : (el != 3'd0);
  wire [DW-1:0] wdat = march ? {DW{dbit}} : ((md == 2'd1) ? (pattern ^ {DW{inv}}) : pattern);
  wire running = (st == S_RUN);
  wire miss = pv && (mem_rdata != pexp);
  wire [RW:0] rc_nx = {1'b0, rc} + 1'b1;
  wire rlast = rc_nx >= {1'b0, repeat_cnt};
  wire [SW:0] cnt_nx = {1'b0, cnt} + 1'b1;
  wire settled = cnt_nx >= {1'b0, settle_cycles};
  wire a_end = down ? (addr == '0) : (addr == ATOP);
  wire nxt_down = (el == 3'd1) || (el == 3'd3);

  assign mem_addr  = addr;
  assign mem_we    = running & ~is_rd;
  assign mem_re    = running & is_rd;
  assign mem_wdata = wdat;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; md <= '0; el <= '0; op <= '0; addr <= '0; cnt <= '0; rc <= '0;
      inv <= 1'b0; pv <= 1'b0; pexp <= '0; paddr <= '0; sup_low_req <= 1'b0;
      fail <= 1'b0; fail_addr <= '0; fail_exp <= '0; fail_mode <= '0;
    end else begin
      pv <= mem_re;
      pexp <= wdat;
      paddr <= addr;
      if (miss && !fail) begin
        fail <= 1'b1; fail_addr <= paddr; fail_exp <= pexp; fail_mode <= md;
      end
      case (st)
        S_IDLE: if (start) begin
          md <= mode; el <= '0; op <= '0; rc <= '0; fail <= 1'b0;
          addr <= (mode == 2'd2) ? tgt_addr : '0;
          if (mode == 2'd1) begin sup_low_req <= 1'b1; st <= S_SUP; end
          else st <= S_RUN;
        end
        S_SUP: if (sup_ack == sup_low_req) begin cnt <= '0; st <= S_WAIT; end
        S_WAIT: if (settled) st <= S_RUN; else cnt <= cnt + 1'b1;
        S_RUN: begin
          if (march) begin
            if (op == nops - 2'd1) begin
              op <= '0;
              if (a_end) begin
                if (el == EL_LAST) st <= S_FLUSH;
                else begin el <= el + 3'd1; addr <= nxt_down ? ATOP : '0; end
              end else addr <= down ? addr - 1'b1 : addr + 1'b1;
            end else op <= op + 2'd1;
          end else if (md == 2'd1) begin
            if (addr == ATOP) begin
              addr <= '0;
              if (el == 3'd0) begin el <= 3'd1; sup_low_req <= 1'b0; st <= S_SUP; end
              else begin inv <= ~inv; st <= S_FLUSH; end
            end else addr <= addr + 1'b1;
          end else begin
            if (el == 3'd0) el <= 3'd1;
            else if (rlast) st <= S_FLUSH;
            else rc <= rc + 1'b1;
          end
          if (miss && stop_on_fail) st <= S_DONE;
        end
        S_FLUSH: st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r5_no_read_at_low: assert property (@(posedge clk) disable iff (!rst_n)
    sup_low_req |-> !mem_re);
  a_r6_quiet_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sup_low_req) |-> !(mem_we || mem_re));
  a_r6_quiet_on_raise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_low_req) |-> !(mem_we || mem_re));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r3_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail) |-> $past(start));
  a_r8_same_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && md == 2'd2) |-> $stable(mem_addr));
endmodule

// File: tb/mbist_seq_tb.sv
module mbist_seq_tb;
  localparam int AW = 7, DW = 32, SW = 16, RW = 4, NW = 1 << AW, TMAX = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 1'b0, stop_on_fail = 1'b0;
  logic [1:0] mode = '0;
  logic [DW-1:0] pattern = '0;
  logic [AW-1:0] tgt_addr = '0;
  logic [SW-1:0] settle_cycles = '0;
  logic [RW-1:0] repeat_cnt = '0;
  logic [AW-1:0] mem_addr, fail_addr;
  logic mem_we, mem_re, sup_low_req, sup_ack, busy, done, fail;
  logic [DW-1:0] mem_wdata, fail_exp;
  logic [DW-1:0] mem_rdata = '0;
  logic [1:0] fail_mode;

  mbist_seq #(.AW(AW), .DW(DW), .SW(SW), .RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .stop_on_fail(stop_on_fail),
    .pattern(pattern), .tgt_addr(tgt_addr), .settle_cycles(settle_cycles),
    .repeat_cnt(repeat_cnt), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sup_low_req(sup_low_req),
    .sup_ack(sup_ack), .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_mode(fail_mode));

  logic [DW-1:0] mem [NW];
  logic flt_en = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic [DW-1:0] flt_mask = '0;
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr] ^ ((flt_en && mem_addr == flt_addr) ? flt_mask : '0);
  end

  logic [3:0] sreg = '0;
  always @(posedge clk) sreg <= {sreg[2:0], sup_low_req};
  assign sup_ack = sreg[3];

  int tot = 0, bad = 0, cyc = 0, n_ops = 0, n_done = 0, ngap = 0, ack_cyc = 0;
  int gap [2];
  logic gap_armed = 1'b0, ack_q = 1'b0;
  logic tr_rd [TMAX];
  logic tr_low [TMAX];
  logic [AW-1:0] tr_a [TMAX];
  logic [DW-1:0] tr_d [TMAX];

  always @(negedge clk) begin
    cyc++;
    if (done) n_done++;
    if (sup_ack != ack_q) begin ack_cyc = cyc; gap_armed = 1'b1; end
    ack_q = sup_ack;
    if (mem_we || mem_re) begin
      if (gap_armed && ngap < 2) begin gap[ngap] = cyc - ack_cyc; ngap++; end
      gap_armed = 1'b0;
      if (n_ops < TMAX) begin
        tr_rd[n_ops] = mem_re; tr_low[n_ops] = sup_low_req;
        tr_a[n_ops] = mem_addr; tr_d[n_ops] = mem_wdata;
      end
      n_ops++;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tot++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic go(input logic [1:0] m, input logic sof, input int poke);
    int wd;
    @(posedge clk); #1;
    n_ops = 0; n_done = 0; ngap = 0; gap_armed = 1'b0;
    mode = m; stop_on_fail = sof; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    wd = 0;
    while (!done && wd < 40000) begin
      start = (wd == poke);
      if (wd == poke) mode = 2'd2;
      @(posedge clk); #1; wd++;
    end
    start = 1'b0;
    if (!done) begin
      tot++; bad++;
      $display("FAIL R9 run watchdog: actual=no done expected=done");
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  function automatic logic [AW+1:0] exp_march(input int i);
    int j, a; logic rd, d;
    if (i < NW) begin rd = 1'b0; d = 1'b1; a = i; end
    else if (i < 4*NW) begin j = i - NW; a = j / 3; rd = (j % 3 == 1); d = (j % 3 == 2); end
    else if (i < 6*NW) begin j = i - 4*NW; a = NW - 1 - j / 2; rd = (j % 2 == 0); d = (j % 2 == 0); end
    else if (i < 8*NW) begin j = i - 6*NW; a = j / 2; rd = (j % 2 == 0); d = (j % 2 == 1); end
    else begin j = i - 8*NW; a = NW - 1 - j; rd = 1'b1; d = 1'b1; end
    return {rd, d, a[AW-1:0]};
  endfunction

  task automatic verify_march(input int nexp);
    int e1, e2; logic [AW+1:0] e; logic ok;
    e1 = 0; e2 = 0;
    chk("R2", "march op count", n_ops, nexp);
    for (int i = 0; i < n_ops && i < TMAX; i++) begin
      e = exp_march(i);
      ok = (tr_rd[i] == e[AW+1]) && (tr_a[i] == e[AW-1:0]) && (tr_rd[i] || tr_d[i] == {DW{e[AW]}});
      if (!ok) begin if (i < 4*NW) e1++; else e2++; end
    end
    chk("R1", "fill and w0-r0-w1 order errors", e1, 0);
    chk("R2", "later march element errors", e2, 0);
  endtask

  task automatic verify_lv(input logic [DW-1:0] p, input int settle);
    int errs, gexp;
    errs = 0;
    chk("R5", "low-supply op count", n_ops, 2*NW);
    for (int i = 0; i < n_ops && i < TMAX; i++) begin
      if (i < NW) begin
        if (tr_rd[i] || tr_a[i] != AW'(i) || !tr_low[i] || tr_d[i] != p) errs++;
      end else begin
        if (!tr_rd[i] || tr_a[i] != AW'(i - NW) || tr_low[i] || tr_d[i] != p) errs++;
      end
    end
    chk("R5", "write-then-read phase errors", errs, 0);
    chk("R7", "low-supply data word", (n_ops > 0) ? tr_d[0] : 0, p);
    gexp = ((settle == 0) ? 1 : settle) + 1;
    chk("R6", "settle gap count", ngap, 2);
    chk("R6", "gap after raise", gap[0], gexp);
    chk("R6", "gap after drop", gap[1], gexp);
  endtask

  task automatic verify_stress(input logic [DW-1:0] p, input logic [AW-1:0] t, input int rep);
    int errs, nr;
    errs = 0;
    nr = (rep == 0) ? 1 : rep;
    chk("R8", "stress op count", n_ops, nr + 1);
    if (tr_rd[0] || tr_a[0] != t || tr_d[0] != p) errs++;
    for (int i = 1; i < n_ops && i < TMAX; i++)
      if (!tr_rd[i] || tr_a[i] != t) errs++;
    chk("R8", "stress op errors", errs, 0);
  endtask

  initial begin
    logic [AW-1:0] fa;
    logic [DW-1:0] p;
    logic lv_inv;
    int s, rep, seedv;
    lv_inv = 1'b0;
    seedv = $urandom(32'd20240611);
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R9", "reset busy", busy, 0);
    chk("R9", "reset done", done, 0);
    chk("R9", "reset fail", fail, 0);
    chk("R9", "reset strobes", {mem_we, mem_re, sup_low_req}, 0);

    go(2'd0, 1'b0, -1);
    verify_march(9*NW);
    chk("R9", "single done pulse", n_done, 1);
    chk("R3", "clean march fail", fail, 0);

    fa = AW'($urandom); flt_mask = $urandom | 32'h1; flt_addr = fa; flt_en = 1'b1;
    go(2'd0, 1'b0, -1);
    chk("R4", "run continues after miscompare", n_ops, 9*NW);
    chk("R3", "fail set", fail, 1);
    chk("R3", "fail address", fail_addr, fa);
    chk("R3", "fail expected word", fail_exp, 0);
    chk("R3", "fail mode", fail_mode, 0);

    go(2'd0, 1'b1, -1);
    chk("R4", "stop-on-fail op count", n_ops, NW + 3*fa + 3);
    chk("R4", "stop-on-fail flag", fail, 1);
    chk("R4", "stop-on-fail done pulse", n_done, 1);

    flt_en = 1'b0;
    go(2'd3, 1'b0, -1);
    verify_march(9*NW);
    chk("R10", "mode 3 march fail", fail, 0);
    chk("R3", "fail cleared on new start", fail, 0);

    for (int k = 0; k < 3; k++) begin
      p = $urandom;
      s = (k == 2) ? 0 : 1 + int'($urandom % 40);
      pattern = p; settle_cycles = SW'(s);
      if (k == 2) begin fa = AW'($urandom); flt_addr = fa; flt_mask = $urandom | 32'h100; flt_en = 1'b1; end
      go(2'd1, 1'b0, -1);
      verify_lv(lv_inv ? ~p : p, s);
      if (k == 2) begin
        chk("R3", "low-supply fail address", fail_addr, fa);
        chk("R3", "low-supply fail word", fail_exp, lv_inv ? ~p : p);
        chk("R3", "low-supply fail mode", fail_mode, 1);
      end else chk("R5", "clean low-supply fail", fail, 0);
      lv_inv = ~lv_inv;
      flt_en = 1'b0;
    end

    for (int k = 0; k < 8; k++) begin
      p = $urandom; fa = AW'($urandom);
      rep = (k == 0) ? 0 : (k == 1) ? 15 : int'($urandom % 16);
      pattern = p; tgt_addr = fa; repeat_cnt = RW'(rep);
      flt_en = k[0]; flt_addr = fa; flt_mask = $urandom | 32'h8;
      go(2'd2, 1'b0, -1);
      verify_stress(p, fa, rep);
      chk("R8", "stress fail flag", fail, k[0]);
      if (k[0]) begin
        chk("R8", "stress fail word", fail_exp, p);
        chk("R8", "stress fail mode", fail_mode, 2);
      end
    end
    flt_en = 1'b0;

    go(2'd0, 1'b0, 200);
    verify_march(9*NW);
    chk("R9", "start while busy ignored, done count", n_done, 1);

    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    tot++; bad++;
    $display("FAIL R9 global watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule